// File: doc/BRIEF.md
# Lock Elision Speculation Controller

This controller sits beside the retire stage and sees one retired memory operation per cycle, along with snoop and resource indications from the cache side. It looks for a lock acquire: a load-locked that finds the lock free, followed by a store-conditional to the same address. When it finds one and the PC's confidence allows, it tells the pipeline to drop that store. It also asks for a register checkpoint and enters speculative mode. Later, a plain store to the lock address that writes back the value the load-locked returned is treated as the release. That store is also dropped and the speculative state is committed. The acquire and release stores cancel each other, so the lock word never changes and other threads can run the same critical section at the same time.

Speculation ends in an abort in several cases: another agent writes the lock word, a data conflict is reported, the write buffer overflows, access tracking is lost, or an uncached access retires. Every abort restores the checkpoint and bumps a restart counter. Execution then replays from the acquire store. Once the counter has reached the limit, the replayed acquire is performed for real and the controller waits in a non-speculative mode until the lock is released. Each acquire PC has a 2-bit saturating confidence value in a small table, which gates whether elision is tried at all.

The state machine has four states:
- IDLE → ARMED on a load-locked that returns the free value.
- ARMED:
  - ARMED → ARMED on another free load-locked, which records the new lock.
  - ARMED → IDLE on a held load-locked or on a snoop write to the lock.
  - ARMED → IDLE on a matching store-conditional with low confidence.
  - ARMED → SPEC on a matching store-conditional that is elided.
  - ARMED → FALLBACK on a matching store-conditional once the restart limit is reached.
- SPEC → ARMED on any violation (abort), and SPEC → IDLE on the matching release (commit).
- FALLBACK → IDLE on the restoring store.

Top module: `lock_elide_ctrl`

## Requirements
- R1: After reset the state is IDLE and every output is 0. All confidence entries hold 2 and the restart count is 0.
- R2: Operation kinds are encoded load=0, store=1, load-locked=2, store-conditional=3. A load-locked whose data differs from the free value (0) does not arm, so a following store-conditional to that address is not elided and no checkpoint is taken.
- R3: In ARMED, a store-conditional to the recorded address raises elide and ckpt_take in that same cycle, provided the restart count is below the limit and confidence is at least 2. spec_active is 1 from the next cycle. A store-conditional to another address is not elided.
- R4: In SPEC, a store to the lock address whose data equals the recorded load-locked value, with no violation present, raises elide, commit and ckpt_release in that cycle. spec_active is 0 from the next cycle.
- R5: In SPEC, a store to the lock address with any other data is neither elided nor committed, and speculation continues.
- R6: In SPEC, a snoop write to the lock address raises abort and ckpt_restore in that cycle. A snoop write to any other address has no effect.
- R7: In SPEC, each of conflict, wb_overflow, track_lost and uncached_access raises abort and ckpt_restore in that cycle.
- R8: A violation in the same cycle as a matching release wins: abort is raised and neither commit nor elide is.
- R9: An abort increments the restart count and returns to ARMED. The replayed store-conditional is then not elided once the count reaches the limit (default 1). nonspec_mode is then 1 from the next cycle until a store writes the recorded value back to the lock address, and 0 after it.
- R10: Both a commit and the end of non-speculative mode clear the restart count, so the next acquire speculates again.
- R11: Confidence is a 2-bit saturating value per table entry. The entry index is the XOR of the consecutive 5-bit slices of the store-conditional PC. The value goes up on commit and down on abort, and elision is attempted only when it is at least 2.
- R12: Only one level is elided: load-locked and store-conditional inside SPEC are ordinary operations, not elided, and take no checkpoint.
- R13: spec_active and nonspec_mode are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A retired memory operation is present |
| op_kind | input | 2 | 0 load, 1 store, 2 load-locked, 3 store-conditional |
| op_pc | input | PC_W | PC of the operation |
| op_addr | input | ADDR_W | Address of the operation |
| op_data | input | DATA_W | Loaded value (loads) or stored value (stores) |
| snoop_wr_valid | input | 1 | Another agent writes memory |
| snoop_wr_addr | input | ADDR_W | Address of that external write |
| conflict | input | 1 | Atomicity violation seen by access tracking |
| wb_overflow | input | 1 | Speculative write buffer is full |
| track_lost | input | 1 | A tracked line was evicted |
| uncached_access | input | 1 | An uncached access retired |
| elide | output | 1 | Suppress the current store |
| ckpt_take | output | 1 | Take the register checkpoint |
| ckpt_restore | output | 1 | Restore the register checkpoint |
| ckpt_release | output | 1 | Discard the register checkpoint |
| commit | output | 1 | Commit buffered speculative state |
| abort | output | 1 | Misspeculation, replay from the acquire store |
| nonspec_mode | output | 1 | Lock is really held, no speculation |
| spec_active | output | 1 | Speculative critical section running |

## Verification
The bench aims at release matching. It sweeps several wrong release values, which a design that matched on address alone would commit, and it lands a violation on the release cycle, where a design with the wrong priority would commit over a conflict. It runs every abort cause in turn and follows each one through replay and the real acquire. A controller that replayed speculatively forever, or never left non-speculative mode, would fail here. It also drives aliasing PCs to an entry held at its upper bound, where a confidence counter that wrapped instead of saturating would stop eliding a lock it should still elide.

// File: rtl/lock_elide_pkg.sv
package lock_elide_pkg;

    // Kind of retired memory operation
    typedef enum logic [1:0] {
        OPK_LOAD   = 2'd0,
        OPK_STORE  = 2'd1,
        OPK_LL     = 2'd2,
        OPK_SC     = 2'd3
    } op_kind_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_SPEC     = 2'd2,
        ST_FALLBACK = 2'd3
    } elide_state_e;

    // Control actions produced by the output process
    typedef struct packed {
        logic cap_lock;
        logic cap_pc;
        logic conf_inc;
        logic conf_dec;
        logic retry_inc;
        logic retry_clr;
    } elide_ctl_t;

endpackage

// File: rtl/lock_conf_table.sv
module lock_conf_table #(
    parameter int PC_W      = 32,
    parameter int ENTRIES   = 32,
    parameter int CONF_W    = 2,
    parameter int CONF_INIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   rd_pc,
    output logic [CONF_W-1:0] rd_conf,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_inc,
    input  logic              upd_dec
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int NSLICE = (PC_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NSLICE * IDX_W;
    localparam logic [CONF_W-1:0] C_MAX  = '1;
    localparam logic [CONF_W-1:0] C_INIT = CONF_W'(CONF_INIT);

    // XOR-fold every PC bit into the table index
    function automatic logic [IDX_W-1:0] fold_pc(input logic [PC_W-1:0] pc);
        logic [PAD_W-1:0] padded;
        logic [IDX_W-1:0] acc;
        padded = PAD_W'(pc);
        acc    = '0;
        for (int s = 0; s < NSLICE; s++) begin
            acc = acc ^ padded[s*IDX_W +: IDX_W];
        end
        return acc;
    endfunction

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  up_idx;
    logic [CONF_W-1:0] conf_q [ENTRIES];

    assign rd_idx  = fold_pc(rd_pc);
    assign up_idx  = fold_pc(upd_pc);
    assign rd_conf = conf_q[rd_idx];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = (up_idx == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                conf_q[e] <= C_INIT;
            end else if (hit && upd_inc && conf_q[e] != C_MAX) begin
                conf_q[e] <= conf_q[e] + 1'b1;
            end else if (hit && upd_dec && conf_q[e] != '0) begin
                conf_q[e] <= conf_q[e] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lock_retry_ctr.sv
module lock_retry_ctr #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q < LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q >= LIM);

endmodule

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl
    import lock_elide_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CONF_ENTRIES = 32,
    parameter int CONF_W      = 2,
    parameter int CONF_INIT   = 2,
    parameter int CONF_MIN    = 2,
    parameter int RETRY_LIMIT = 1,
    parameter int FREE_VAL    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [PC_W-1:0]   op_pc,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              snoop_wr_valid,
    input  logic [ADDR_W-1:0] snoop_wr_addr,
    input  logic              conflict,
    input  logic              wb_overflow,
    input  logic              track_lost,
    input  logic              uncached_access,
    output logic              elide,
    output logic              ckpt_take,
    output logic              ckpt_restore,
    output logic              ckpt_release,
    output logic              commit,
    output logic              abort,
    output logic              nonspec_mode,
    output logic              spec_active
);
    localparam logic [DATA_W-1:0] FREE_WORD = DATA_W'(FREE_VAL);
    localparam logic [CONF_W-1:0] CONF_GATE = CONF_W'(CONF_MIN);

    elide_state_e      state_q, state_d;
    logic [ADDR_W-1:0] lk_addr_q;
    logic [DATA_W-1:0] lk_val_q;
    logic [PC_W-1:0]   lk_pc_q;
    elide_ctl_t        ctl;

    // Decoded view of the current operation
    logic is_ll, is_sc, is_st, addr_hit, ld_free;
    logic snoop_hit, viol, release_hit, conf_ok, retry_hit;
    logic [CONF_W-1:0] rd_conf;

    assign is_ll       = op_valid && (op_kind == OPK_LL);
    assign is_sc       = op_valid && (op_kind == OPK_SC);
    assign is_st       = op_valid && (op_kind == OPK_STORE);
    assign addr_hit    = (op_addr == lk_addr_q);
    assign ld_free     = (op_data == FREE_WORD);
    assign snoop_hit   = snoop_wr_valid && (snoop_wr_addr == lk_addr_q);
    assign viol        = snoop_hit || conflict || wb_overflow ||
                         track_lost || uncached_access;
    assign release_hit = is_st && addr_hit && (op_data == lk_val_q);
    assign conf_ok     = (rd_conf >= CONF_GATE);

    lock_conf_table #(
        .PC_W      (PC_W),
        .ENTRIES   (CONF_ENTRIES),
        .CONF_W    (CONF_W),
        .CONF_INIT (CONF_INIT)
    ) u_conf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_pc   (op_pc),
        .rd_conf (rd_conf),
        .upd_pc  (lk_pc_q),
        .upd_inc (ctl.conf_inc),
        .upd_dec (ctl.conf_dec)
    );

    lock_retry_ctr #(
        .LIMIT (RETRY_LIMIT)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (ctl.retry_inc),
        .clr     (ctl.retry_clr),
        .reached (retry_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_ll && ld_free) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (snoop_hit) begin
                    state_d = ST_IDLE;
                end else if (is_ll) begin
                    state_d = ld_free ? ST_ARMED : ST_IDLE;
                end else if (is_sc && addr_hit) begin
                    if (retry_hit)    state_d = ST_FALLBACK;
                    else if (conf_ok) state_d = ST_SPEC;
                    else              state_d = ST_IDLE;
                end
            end
            ST_SPEC: begin
                if (viol)             state_d = ST_ARMED;
                else if (release_hit) state_d = ST_IDLE;
            end
            ST_FALLBACK: begin
                if (release_hit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and action logic
    always_comb begin
        elide        = 1'b0;
        ckpt_take    = 1'b0;
        ckpt_restore = 1'b0;
        ckpt_release = 1'b0;
        commit       = 1'b0;
        abort        = 1'b0;
        ctl          = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctl.cap_lock = is_ll && ld_free;
            end
            ST_ARMED: begin
                if (!snoop_hit) begin
                    if (is_ll) begin
                        ctl.cap_lock = ld_free;
                    end else if (is_sc && addr_hit && !retry_hit && conf_ok) begin
                        elide      = 1'b1;
                        ckpt_take  = 1'b1;
                        ctl.cap_pc = 1'b1;
                    end
                end
            end
            ST_SPEC: begin
                if (viol) begin
                    abort         = 1'b1;
                    ckpt_restore  = 1'b1;
                    ctl.conf_dec  = 1'b1;
                    ctl.retry_inc = 1'b1;
                end else if (release_hit) begin
                    elide         = 1'b1;
                    commit        = 1'b1;
                    ckpt_release  = 1'b1;
                    ctl.conf_inc  = 1'b1;
                    ctl.retry_clr = 1'b1;
                end
            end
            ST_FALLBACK: begin
                ctl.retry_clr = release_hit;
            end
            default: ;
        endcase
    end

    assign spec_active  = (state_q == ST_SPEC);
    assign nonspec_mode = (state_q == ST_FALLBACK);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Recorded lock context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_addr_q <= '0;
            lk_val_q  <= '0;
            lk_pc_q   <= '0;
        end else begin
            if (ctl.cap_lock) begin
                lk_addr_q <= op_addr;
                lk_val_q  <= op_data;
            end
            if (ctl.cap_pc) begin
                lk_pc_q <= op_pc;
            end
        end
    end

endmodule

// File: rtl/lock_elide_chk.sv
module lock_elide_chk
    import lock_elide_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic       elide,
    input logic       ckpt_take,
    input logic       ckpt_restore,
    input logic       ckpt_release,
    input logic       commit,
    input logic       abort,
    input logic       nonspec_mode,
    input logic       spec_active
);
    // R3
    take_enters_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take |=> spec_active);

    // R4
    commit_exits_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !spec_active);

    // R4
    commit_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (ckpt_release && elide && spec_active));

    // R2
    elide_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elide |-> (op_valid && (op_kind == OPK_STORE || op_kind == OPK_SC)));

    // R6
    abort_in_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (spec_active && ckpt_restore));

    // R8
    commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && abort));

    // R12
    single_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_active |-> !ckpt_take);

    // R13
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spec_active && nonspec_mode));

    // R9
    fallback_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nonspec_mode |-> !(elide || ckpt_take || ckpt_restore || commit));

endmodule

bind lock_elide_ctrl lock_elide_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .elide        (elide),
    .ckpt_take    (ckpt_take),
    .ckpt_restore (ckpt_restore),
    .ckpt_release (ckpt_release),
    .commit       (commit),
    .abort        (abort),
    .nonspec_mode (nonspec_mode),
    .spec_active  (spec_active)
);

// File: tb/lock_elide_ctrl_bench.sv
module lock_elide_ctrl_bench;
    localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_LL = 2'd2, K_SC = 2'd3;
    localparam logic [31:0] LOCK  = 32'h100;
    localparam logic [31:0] OTHER = 32'h200;
    localparam logic [31:0] PC_A  = 32'h10;   // index 16
    localparam logic [31:0] PC_AL = 32'h31;   // 17 ^ 1 = index 16
    localparam logic [31:0] PC_B  = 32'h12;   // index 18
    localparam logic [31:0] PC_N  = 32'h300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [31:0] op_pc = '0, op_addr = '0, op_data = '0;
    logic        snoop_wr_valid = 1'b0;
    logic [31:0] snoop_wr_addr = '0;
    logic        conflict = 1'b0, wb_overflow = 1'b0, track_lost = 1'b0, uncached_access = 1'b0;
    logic elide, ckpt_take, ckpt_restore, ckpt_release, commit, abort, nonspec_mode, spec_active;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lock_elide_ctrl u_lock_elide_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_pc(op_pc), .op_addr(op_addr), .op_data(op_data),
        .snoop_wr_valid(snoop_wr_valid), .snoop_wr_addr(snoop_wr_addr),
        .conflict(conflict), .wb_overflow(wb_overflow), .track_lost(track_lost),
        .uncached_access(uncached_access), .elide(elide), .ckpt_take(ckpt_take),
        .ckpt_restore(ckpt_restore), .ckpt_release(ckpt_release), .commit(commit),
        .abort(abort), .nonspec_mode(nonspec_mode), .spec_active(spec_active)
    );

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs are sampled 1 ns after the falling edge
    task automatic cyc(input logic v, input logic [1:0] k, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic sw, input logic [31:0] swa, input logic [3:0] side);
        @(negedge clk);
        op_valid = v; op_kind = k; op_pc = pc; op_addr = a; op_data = d;
        snoop_wr_valid = sw; snoop_wr_addr = swa;
        {uncached_access, track_lost, wb_overflow, conflict} = side;
        #1;
    endtask

    task automatic op(input logic [1:0] k, input logic [31:0] pc,
                      input logic [31:0] a, input logic [31:0] d);
        cyc(1'b1, k, pc, a, d, 1'b0, '0, 4'd0);
    endtask

    task automatic idle();
        cyc(1'b0, K_LD, '0, '0, '0, 1'b0, '0, 4'd0);
    endtask

    // Complete a non-speculative acquire after the replayed store-conditional
    task automatic finish_fallback(input string tag, input logic [31:0] pc);
        op(K_SC, pc, LOCK, 32'd1);
        ck({tag, " replay not elided"}, {31'd0, elide | ckpt_take}, 32'd0);
        idle();
        ck({tag, " nonspec set"}, {31'd0, nonspec_mode}, 32'd1);
        op(K_ST, PC_N, LOCK, 32'd0);
        ck({tag, " fallback release not elided"}, {31'd0, elide | commit}, 32'd0);
        idle();
        ck({tag, " nonspec cleared"}, {31'd0, nonspec_mode}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        ck("R1 outputs in reset", {24'd0, elide, ckpt_take, ckpt_restore, ckpt_release,
            commit, abort, nonspec_mode, spec_active}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        ck("R1 outputs after reset", {24'd0, elide, ckpt_take, ckpt_restore, ckpt_release,
            commit, abort, nonspec_mode, spec_active}, 32'd0);

        // R2 held lock does not arm
        op(K_LL, PC_A, LOCK, 32'd1);
        op(K_SC, PC_A, LOCK, 32'd1);
        ck("R2 held lock elide", {31'd0, elide}, 32'd0);
        ck("R2 held lock ckpt_take", {31'd0, ckpt_take}, 32'd0);
        idle();
        ck("R2 held lock spec", {31'd0, spec_active}, 32'd0);

        // R3 acquire elided, R1 confidence starts at 2
        op(K_LL, PC_A, LOCK, 32'd0);
        op(K_SC, PC_A, LOCK, 32'd1);
        ck("R3 elide on acquire", {31'd0, elide}, 32'd1);
        ck("R3 ckpt_take on acquire", {31'd0, ckpt_take}, 32'd1);
        idle();
        ck("R3 spec_active next cycle", {31'd0, spec_active}, 32'd1);
        // R5 sweep of wrong release values
        for (int v = 1; v <= 4; v++) begin
            op(K_ST, PC_N, LOCK, 32'(v));
            ck("R5 wrong value not elided", {31'd0, elide}, 32'd0);
            ck("R5 wrong value no commit", {31'd0, commit}, 32'd0);
        end
        idle();
        ck("R5 still speculative", {31'd0, spec_active}, 32'd1);
        // R6 external write elsewhere is ignored
        cyc(1'b0, K_LD, '0, '0, '0, 1'b1, OTHER, 4'd0);
        ck("R6 foreign snoop no abort", {31'd0, abort}, 32'd0);
        // R12 nested pair is ordinary
        op(K_LL, PC_N, LOCK, 32'd0);
        op(K_SC, PC_N, LOCK, 32'd1);
        ck("R12 nested sc not elided", {31'd0, elide}, 32'd0);
        ck("R12 nested sc no checkpoint", {31'd0, ckpt_take}, 32'd0);
        // R4 release
        op(K_ST, PC_N, LOCK, 32'd0);
        ck("R4 release elided", {31'd0, elide}, 32'd1);
        ck("R4 commit", {31'd0, commit}, 32'd1);
        ck("R4 ckpt_release", {31'd0, ckpt_release}, 32'd1);
        ck("R4 no abort", {31'd0, abort}, 32'd0);
        idle();
        ck("R4 spec cleared", {31'd0, spec_active}, 32'd0);

        // R3 store-conditional to another address
        op(K_LL, PC_A, LOCK, 32'd0);
        op(K_SC, PC_A, OTHER, 32'd1);
        ck("R3 other address not elided", {31'd0, elide}, 32'd0);
        op(K_SC, PC_A, LOCK, 32'd1);
        ck("R3 matching sc elided", {31'd0, elide}, 32'd1);
        op(K_ST, PC_N, LOCK, 32'd0);
        ck("R4 second commit", {31'd0, commit}, 32'd1);

        // R6/R7 sweep over every abort cause, then replay and real acquire (R9)
        for (int c = 0; c < 5; c++) begin
            string tg;
            logic [31:0] pcc;
            tg  = (c == 0) ? "R6" : "R7";
            pcc = 32'(c);
            op(K_LL, pcc, LOCK, 32'd0);
            op(K_SC, pcc, LOCK, 32'd1);
            ck({tg, " setup elide"}, {31'd0, elide}, 32'd1);
            if (c == 0) cyc(1'b0, K_LD, '0, '0, '0, 1'b1, LOCK, 4'd0);
            else        cyc(1'b0, K_LD, '0, '0, '0, 1'b0, '0, 4'(1 << (c - 1)));
            ck({tg, " abort"}, {31'd0, abort}, 32'd1);
            ck({tg, " ckpt_restore"}, {31'd0, ckpt_restore}, 32'd1);
            ck({tg, " no commit"}, {31'd0, commit}, 32'd0);
            idle();
            ck({tg, " spec cleared"}, {31'd0, spec_active}, 32'd0);
            finish_fallback("R9", pcc);
        end

        // R11 confidence at index 0 is now 1: no elision
        op(K_LL, 32'd0, LOCK, 32'd0);
        op(K_SC, 32'd0, LOCK, 32'd1);
        ck("R11 low confidence not elided", {31'd0, elide}, 32'd0);
        idle();
        ck("R11 low confidence no spec", {31'd0, spec_active | nonspec_mode}, 32'd0);

        // R10 restart count cleared by the fallback release
        op(K_LL, PC_B, LOCK, 32'd0);
        op(K_SC, PC_B, LOCK, 32'd1);
        ck("R10 speculates again", {31'd0, elide}, 32'd1);
        // R8 violation on the release cycle
        cyc(1'b1, K_ST, PC_N, LOCK, 32'd0, 1'b0, '0, 4'b0001);
        ck("R8 abort wins", {31'd0, abort}, 32'd1);
        ck("R8 no commit", {31'd0, commit}, 32'd0);
        ck("R8 no elide", {31'd0, elide}, 32'd0);
        finish_fallback("R8", PC_B);

        // R11 saturation at 3 and aliasing PCs sharing index 16
        op(K_LL, PC_AL, LOCK, 32'd0);
        op(K_SC, PC_AL, LOCK, 32'd1);
        ck("R11 saturated entry elides", {31'd0, elide}, 32'd1);
        cyc(1'b0, K_LD, '0, '0, '0, 1'b0, '0, 4'b0010);
        ck("R11 alias abort", {31'd0, abort}, 32'd1);
        finish_fallback("R11", PC_AL);
        op(K_LL, PC_A, LOCK, 32'd0);
        op(K_SC, PC_A, LOCK, 32'd1);
        ck("R11 confidence 2 still elides", {31'd0, elide}, 32'd1);
        cyc(1'b0, K_LD, '0, '0, '0, 1'b0, '0, 4'b0100);
        ck("R11 second abort", {31'd0, abort}, 32'd1);
        finish_fallback("R11", PC_A);
        op(K_LL, PC_AL, LOCK, 32'd0);
        op(K_SC, PC_AL, LOCK, 32'd1);
        ck("R11 alias confidence 1 not elided", {31'd0, elide}, 32'd0);
        idle();
        ck("R13 both modes clear", {31'd0, spec_active | nonspec_mode}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule